// File: doc/BRIEF.md
# BT.1120 Embedded Sync Decoder

This block takes a 16-bit progressive BT.1120 stream sampled on the rising pixel clock only. Luma arrives on the upper byte lane and chroma on the lower one. The decoder searches the luma lane for a programmable three-word preamble and reads the word that follows as a timing status word. It checks the status word's protection bits and packs its H, V and F bits into a 3-bit event code. That code is compared against four programmable codes: active start, active end, blanking start and blanking end.

From the matched events it derives several outputs. Line and frame strobes mark the start of each active line and of each frame. A field flag follows the F bit. An active-video qualifier frames each line. Active samples are paired into 4:2:2 pixel pairs in U-Y-V-Y order, and the pixels per line and lines per frame are measured. The chroma lane must carry the same preamble as the luma lane, and a mismatch raises an error flag. A status word that fails protection is discarded and counted.

Top module: `bt1120_sync_decoder`

## Requirements
- R1: A timing reference is found when three consecutive luma samples equal `preamble_i[23:16]`, `preamble_i[15:8]` and `preamble_i[7:0]`, in that order. The next luma sample is the status word. A broken sequence restarts the search, and a first-word value seen mid-search begins a new attempt.
- R2: A status word is good when bit 7 = 1 and the protection bits match the flag bits. The flag bits are F = bit 6, V = bit 5 and H = bit 4. The protection bits must be bit 3 = V^H, bit 2 = F^H, bit 1 = F^V and bit 0 = F^V^H. The event code is {H,V,F}, with H as the MSB.
- R3: A status word that fails R2 changes no timing output and no field flag. It increments `prot_err_cnt_o`, which saturates at its maximum.
- R4: If the chroma lane did not carry the same three preamble words, `sync_err_o` pulses for one cycle after the status word is sampled.
- R5: `video_active_o` rises one edge after a status word matching `code_act_start_i`, and only if that code has V = 0. It falls on a match with the active-end or either blanking code, or on any good word with V = 1.
- R6: While active, each luma sample that is not the first preamble word and is not part of a sync sequence is a video sample. Samples pair from the start of each line. The second sample of a pair pulses `pair_valid_o`, with `pair_o` = {chroma0, luma0, chroma1, luma1}.
- R7: `line_start_o` pulses on each active-start match. `frame_start_o` also pulses on the first active-start match after a blanking code or after reset.
- R8: `line_pixels_o` captures the video sample count of a line on its active-end match. `frame_lines_o` captures the number of active lines of the previous frame at each frame start.
- R9: `field_o` holds the F bit of the most recent good status word.
- R10: The preamble and all four event codes are taken from the inputs. Non-default values retarget detection, and the old preamble is then not recognised.
- R11: Reset (active low) clears every output and counter and returns the search to its idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge only |
| rst_n | input | 1 | Asynchronous active-low reset |
| luma_i | input | 8 | Upper lane: luma and timing words |
| chroma_i | input | 8 | Lower lane: chroma |
| preamble_i | input | 24 | Three preamble words, first in the top byte |
| code_act_start_i | input | 3 | {H,V,F} code for active start |
| code_act_end_i | input | 3 | {H,V,F} code for active end |
| code_blk_start_i | input | 3 | {H,V,F} code for blanking start |
| code_blk_end_i | input | 3 | {H,V,F} code for blanking end |
| frame_start_o | output | 1 | Pulse on first active line of a frame |
| line_start_o | output | 1 | Pulse on every active-start match |
| field_o | output | 1 | Last good F bit |
| video_active_o | output | 1 | Active-video qualifier |
| pair_valid_o | output | 1 | Pulse with each completed pixel pair |
| pair_o | output | 32 | U, Y0, V, Y1 |
| sync_err_o | output | 1 | Chroma lane preamble mismatch pulse |
| prot_err_cnt_o | output | 8 | Saturating count of failed status words |
| line_pixels_o | output | 12 | Video samples in the last line |
| frame_lines_o | output | 12 | Active lines in the previous frame |

## Verification
The bench corrupts single protection bits and the marker bit. A decoder that trusted such words would move the field flag or fail to count the error. Broken and restarted preambles are sent to catch a search that locks on non-consecutive words or misses a repeated first word. It checks that the four preamble and status cycles of the end-of-line code never leak into the pixel pairs. It also checks that a line with an odd sample count does not shift the pairing of the next line. Frame strobes and line counts are exercised across a blanking gap. With reprogrammed preamble and codes, a hard-wired decoder would either stay silent or still respond to the default values.

// File: rtl/bt_sync_pkg.sv
package bt_sync_pkg;

  typedef enum logic [1:0] {
    SRCH_IDLE,
    SRCH_W1,
    SRCH_W2,
    SRCH_STAT
  } srch_e;

  // Marker bit set and all four protection bits consistent with F/V/H.
  function automatic logic status_good(input logic [7:0] s);
    logic f, v, h;
    f = s[6];
    v = s[5];
    h = s[4];
    return s[7] && (s[3] == (v ^ h)) && (s[2] == (f ^ h)) &&
           (s[1] == (f ^ v)) && (s[0] == (f ^ v ^ h));
  endfunction

endpackage

// File: rtl/trs_hunter.sv
module trs_hunter
  import bt_sync_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANE_W-1:0]     luma,
  input  logic [LANE_W-1:0]     chroma,
  input  logic [3*LANE_W-1:0]   preamble,
  output logic                  evt_stb,
  output logic                  evt_bad,
  output logic                  lane_mismatch,
  output logic [2:0]            evt_code,
  output logic                  evt_f,
  output logic                  idle_data
);

  localparam int PW = 3 * LANE_W;

  srch_e state_q, state_d;
  logic  cok_q, cok_d;

  logic [LANE_W-1:0] w0, w1, w2;
  logic [7:0]        sw;
  logic              is_stat;

  assign w0 = preamble[PW-1 -: LANE_W];
  assign w1 = preamble[2*LANE_W-1 -: LANE_W];
  assign w2 = preamble[LANE_W-1:0];

  always_comb begin
    state_d = state_q;
    cok_d   = cok_q;
    unique case (state_q)
      SRCH_IDLE: begin
        if (luma == w0) begin
          state_d = SRCH_W1;
          cok_d   = (chroma == w0);
        end
      end
      SRCH_W1: begin
        if (luma == w1) begin
          state_d = SRCH_W2;
          cok_d   = cok_q && (chroma == w1);
        end else if (luma == w0) begin
          state_d = SRCH_W1;
          cok_d   = (chroma == w0);
        end else begin
          state_d = SRCH_IDLE;
        end
      end
      SRCH_W2: begin
        if (luma == w2) begin
          state_d = SRCH_STAT;
          cok_d   = cok_q && (chroma == w2);
        end else if (luma == w0) begin
          state_d = SRCH_W1;
          cok_d   = (chroma == w0);
        end else begin
          state_d = SRCH_IDLE;
        end
      end
      default: state_d = SRCH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SRCH_IDLE;
      cok_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cok_q   <= cok_d;
    end
  end

  assign is_stat       = (state_q == SRCH_STAT);
  assign sw            = luma[LANE_W-1 -: 8];
  assign evt_stb       = is_stat && status_good(sw);
  assign evt_bad       = is_stat && !status_good(sw);
  assign lane_mismatch = is_stat && !cok_q;
  assign evt_code      = {sw[4], sw[5], sw[6]};
  assign evt_f         = sw[6];
  assign idle_data     = (state_q == SRCH_IDLE) && (luma != w0);

  // R1: the status slot is only reached straight after the third preamble word
  p_stat_after_w2_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SRCH_STAT) |-> ($past(state_q) == SRCH_W2 && $past(luma) == $past(w2)))
    else $error("p_stat_after_w2_r1");

endmodule

// File: rtl/pair_packer.sv
module pair_packer #(
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  restart,
  input  logic                  take,
  input  logic [LANE_W-1:0]     luma,
  input  logic [LANE_W-1:0]     chroma,
  output logic                  pair_vld,
  output logic [4*LANE_W-1:0]   pair_data
);

  logic              phase_q, phase_d;
  logic [LANE_W-1:0] hc_q, hc_d, hy_q, hy_d;
  logic [4*LANE_W-1:0] pd_q, pd_d;
  logic              vld_q, vld_d;

  always_comb begin
    phase_d = phase_q;
    hc_d    = hc_q;
    hy_d    = hy_q;
    pd_d    = pd_q;
    vld_d   = 1'b0;
    if (restart) begin
      phase_d = 1'b0;
    end else if (take) begin
      phase_d = !phase_q;
      if (!phase_q) begin
        hc_d = chroma;
        hy_d = luma;
      end else begin
        pd_d  = {hc_q, hy_q, chroma, luma};
        vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      hc_q    <= '0;
      hy_q    <= '0;
      pd_q    <= '0;
      vld_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      hc_q    <= hc_d;
      hy_q    <= hy_d;
      pd_q    <= pd_d;
      vld_q   <= vld_d;
    end
  end

  assign pair_vld  = vld_q;
  assign pair_data = pd_q;

  // R6: a pair is only emitted by the second sample of a pair
  p_pair_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> ($past(take) && $past(phase_q)))
    else $error("p_pair_second_r6");

endmodule

// File: rtl/bt1120_sync_decoder.sv
module bt1120_sync_decoder #(
  parameter int LANE_W = 8,
  parameter int CNT_W  = 12,
  parameter int ERR_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANE_W-1:0]     luma_i,
  input  logic [LANE_W-1:0]     chroma_i,
  input  logic [3*LANE_W-1:0]   preamble_i,
  input  logic [2:0]            code_act_start_i,
  input  logic [2:0]            code_act_end_i,
  input  logic [2:0]            code_blk_start_i,
  input  logic [2:0]            code_blk_end_i,
  output logic                  frame_start_o,
  output logic                  line_start_o,
  output logic                  field_o,
  output logic                  video_active_o,
  output logic                  pair_valid_o,
  output logic [4*LANE_W-1:0]   pair_o,
  output logic                  sync_err_o,
  output logic [ERR_W-1:0]      prot_err_cnt_o,
  output logic [CNT_W-1:0]      line_pixels_o,
  output logic [CNT_W-1:0]      frame_lines_o
);

  logic       evt_stb, evt_bad, lane_mm, evt_f, idle_data;
  logic [2:0] evt_code;

  trs_hunter #(.LANE_W(LANE_W)) u_hunt (
    .clk           (clk),
    .rst_n         (rst_n),
    .luma          (luma_i),
    .chroma        (chroma_i),
    .preamble      (preamble_i),
    .evt_stb       (evt_stb),
    .evt_bad       (evt_bad),
    .lane_mismatch (lane_mm),
    .evt_code      (evt_code),
    .evt_f         (evt_f),
    .idle_data     (idle_data)
  );

  logic act_q, act_d, vbl_q, vbl_d, frm_q, frm_d, lin_q, lin_d;
  logic fld_q, fld_d, serr_q, serr_d;
  logic [ERR_W-1:0] ecnt_q, ecnt_d;
  logic [CNT_W-1:0] pcnt_q, pcnt_d, lcnt_q, lcnt_d, lpix_q, lpix_d, flin_q, flin_d;
  logic hit_as, hit_ae, hit_blk, take;

  assign hit_as  = evt_stb && (evt_code == code_act_start_i) && !code_act_start_i[1];
  assign hit_ae  = evt_stb && (evt_code == code_act_end_i);
  assign hit_blk = evt_stb && ((evt_code == code_blk_start_i) || (evt_code == code_blk_end_i));
  assign take    = act_q && idle_data;

  always_comb begin
    act_d  = act_q;
    vbl_d  = vbl_q;
    fld_d  = fld_q;
    pcnt_d = pcnt_q;
    lcnt_d = lcnt_q;
    lpix_d = lpix_q;
    flin_d = flin_q;
    ecnt_d = ecnt_q;
    frm_d  = hit_as && vbl_q;
    lin_d  = hit_as;
    serr_d = lane_mm;
    if (hit_as)
      act_d = 1'b1;
    else if (hit_ae || hit_blk || (evt_stb && evt_code[1]))
      act_d = 1'b0;
    if (hit_blk)
      vbl_d = 1'b1;
    else if (hit_as)
      vbl_d = 1'b0;
    if (evt_stb)
      fld_d = evt_f;
    if (evt_bad && !(&ecnt_q))
      ecnt_d = ecnt_q + ERR_W'(1);
    if (hit_as)
      pcnt_d = '0;
    else if (take)
      pcnt_d = pcnt_q + CNT_W'(1);
    if (hit_ae)
      lpix_d = pcnt_q;
    if (hit_as) begin
      lcnt_d = vbl_q ? CNT_W'(1) : lcnt_q + CNT_W'(1);
      if (vbl_q)
        flin_d = lcnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      vbl_q  <= 1'b1;
      frm_q  <= 1'b0;
      lin_q  <= 1'b0;
      fld_q  <= 1'b0;
      serr_q <= 1'b0;
      ecnt_q <= '0;
      pcnt_q <= '0;
      lcnt_q <= '0;
      lpix_q <= '0;
      flin_q <= '0;
    end else begin
      act_q  <= act_d;
      vbl_q  <= vbl_d;
      frm_q  <= frm_d;
      lin_q  <= lin_d;
      fld_q  <= fld_d;
      serr_q <= serr_d;
      ecnt_q <= ecnt_d;
      pcnt_q <= pcnt_d;
      lcnt_q <= lcnt_d;
      lpix_q <= lpix_d;
      flin_q <= flin_d;
    end
  end

  pair_packer #(.LANE_W(LANE_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (hit_as),
    .take      (take),
    .luma      (luma_i),
    .chroma    (chroma_i),
    .pair_vld  (pair_valid_o),
    .pair_data (pair_o)
  );

  assign frame_start_o  = frm_q;
  assign line_start_o   = lin_q;
  assign field_o        = fld_q;
  assign video_active_o = act_q;
  assign sync_err_o     = serr_q;
  assign prot_err_cnt_o = ecnt_q;
  assign line_pixels_o  = lpix_q;
  assign frame_lines_o  = flin_q;

  // R5: the qualifier only opens after a good status word with V clear
  p_active_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> ($past(evt_stb) && !$past(evt_code[1])))
    else $error("p_active_rise_r5");

  // R7: a frame strobe only follows blanking and always comes with a line strobe
  p_frame_after_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_q |-> ($past(vbl_q) && lin_q))
    else $error("p_frame_after_blank_r7");

  // R3: the error count moves only by one, and only after a rejected word
  p_err_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ecnt_q != $past(ecnt_q)) |-> ($past(evt_bad) && ecnt_q == $past(ecnt_q) + ERR_W'(1)))
    else $error("p_err_step_r3");

  // R9: the field flag holds unless a good status word arrived
  p_field_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(evt_stb) |-> (fld_q == $past(fld_q)))
    else $error("p_field_hold_r9");

endmodule

// File: tb/sim_bt1120_sync_decoder.sv
module sim_bt1120_sync_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  luma, chroma;
  logic [23:0] pre;
  logic [2:0]  c_as, c_ae, c_bs, c_be;
  logic        frame_start, line_start, field, vact, pvld, serr;
  logic [31:0] pair;
  logic [7:0]  ecnt;
  logic [11:0] lpix, flines;

  int checks = 0;
  int errors = 0;
  int exp_err = 0;
  logic last_fs, last_ls;
  logic [23:0] tx_pre;

  always #10 clk = ~clk;

  bt1120_sync_decoder u0 (
    .clk(clk), .rst_n(rst_n), .luma_i(luma), .chroma_i(chroma),
    .preamble_i(pre), .code_act_start_i(c_as), .code_act_end_i(c_ae),
    .code_blk_start_i(c_bs), .code_blk_end_i(c_be),
    .frame_start_o(frame_start), .line_start_o(line_start), .field_o(field),
    .video_active_o(vact), .pair_valid_o(pvld), .pair_o(pair),
    .sync_err_o(serr), .prot_err_cnt_o(ecnt), .line_pixels_o(lpix),
    .frame_lines_o(flines)
  );

  // status byte: marker, F, V, H, then V^H, F^H, F^V, F^V^H
  function automatic logic [7:0] xy(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] l, input logic [7:0] c);
    @(negedge clk);
    luma   = l;
    chroma = c;
    @(posedge clk);
    #2;
  endtask

  task automatic send_trs(input logic [7:0] s);
    step(tx_pre[23:16], tx_pre[23:16]);
    step(tx_pre[15:8], tx_pre[15:8]);
    step(tx_pre[7:0], tx_pre[7:0]);
    step(s, s);
  endtask

  task automatic run_line(input logic [7:0] sav, input logic [7:0] eav,
                          input int n, input logic exp_act);
    send_trs(sav);
    last_fs = frame_start;
    last_ls = line_start;
    for (int i = 0; i < n; i++) begin
      step(8'h20 + 8'(i), 8'h90 + 8'(i));
      chk("R5 active", {31'd0, vact}, {31'd0, exp_act});
      if (exp_act && (i % 2 == 1)) begin
        chk("R6 pair valid", {31'd0, pvld}, 32'd1);
        chk("R6 pair data", pair,
            {8'h90 + 8'(i - 1), 8'h20 + 8'(i - 1), 8'h90 + 8'(i), 8'h20 + 8'(i)});
      end else begin
        chk("R6 no pair", {31'd0, pvld}, 32'd0);
      end
    end
    send_trs(eav);
    chk("R6 no pair during end code", {31'd0, pvld}, 32'd0);
    if (exp_act) chk("R8 line pixels", {20'd0, lpix}, n);
  endtask

  // {status, chroma on second preamble word, protection error, lane error, field}
  localparam logic [18:0] VEC [6] = '{
    {8'hAB, 8'h00, 1'b0, 1'b0, 1'b0},
    {8'hAA, 8'h00, 1'b1, 1'b0, 1'b0},
    {8'hEC, 8'h00, 1'b0, 1'b0, 1'b1},
    {8'h6C, 8'h00, 1'b1, 1'b0, 1'b1},
    {8'hB6, 8'h5A, 1'b0, 1'b1, 1'b0},
    {8'hA3, 8'h5A, 1'b1, 1'b1, 1'b0}
  };

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    luma = 8'h10; chroma = 8'h80;
    pre = 24'hFF0000; tx_pre = 24'hFF0000;
    c_as = 3'd0; c_ae = 3'd4; c_bs = 3'd2; c_be = 3'd6;
    repeat (3) @(posedge clk);
    #2;
    // R11 reset state
    chk("R11 frame_start", {31'd0, frame_start}, 32'd0);
    chk("R11 active", {31'd0, vact}, 32'd0);
    chk("R11 pair valid", {31'd0, pvld}, 32'd0);
    chk("R11 err count", {24'd0, ecnt}, 32'd0);
    chk("R11 field", {31'd0, field}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 R4 R9 table
    for (int k = 0; k < 6; k++) begin
      step(8'hFF, 8'hFF);
      step(8'h00, VEC[k][10:3]);
      step(8'h00, 8'h00);
      step(VEC[k][18:11], VEC[k][18:11]);
      if (VEC[k][2]) exp_err++;
      chk("R3 err count", {24'd0, ecnt}, exp_err);
      chk("R4 sync err", {31'd0, serr}, {31'd0, VEC[k][1]});
      chk("R9 field", {31'd0, field}, {31'd0, VEC[k][0]});
      chk("R3 no line strobe", {31'd0, line_start}, 32'd0);
    end
    step(8'h10, 8'h80);
    chk("R4 sync err single pulse", {31'd0, serr}, 32'd0);

    // R1 broken preamble, then a restarted one
    step(8'hFF, 8'hFF); step(8'h00, 8'h00); step(8'h11, 8'h11); step(8'h80, 8'h80);
    chk("R1 broken preamble", {31'd0, line_start}, 32'd0);
    chk("R1 broken preamble active", {31'd0, vact}, 32'd0);
    step(8'hFF, 8'hFF); step(8'hFF, 8'hFF); step(8'h00, 8'h00); step(8'h00, 8'h00);
    step(xy(0, 0, 0), xy(0, 0, 0));
    chk("R1 restarted preamble", {31'd0, line_start}, 32'd1);
    chk("R5 active after start", {31'd0, vact}, 32'd1);
    send_trs(xy(0, 0, 1));
    chk("R5 active cleared", {31'd0, vact}, 32'd0);

    // frame: blank, three active lines, blank, active
    run_line(xy(0, 1, 0), xy(0, 1, 1), 4, 1'b0);
    run_line(xy(0, 0, 0), xy(0, 0, 1), 6, 1'b1);
    chk("R7 frame start", {31'd0, last_fs}, 32'd1);
    chk("R7 line start", {31'd0, last_ls}, 32'd1);
    run_line(xy(0, 0, 0), xy(0, 0, 1), 6, 1'b1);
    chk("R7 no frame start mid frame", {31'd0, last_fs}, 32'd0);
    chk("R7 line start mid frame", {31'd0, last_ls}, 32'd1);
    run_line(xy(0, 0, 0), xy(0, 0, 1), 5, 1'b1);
    run_line(xy(0, 1, 0), xy(0, 1, 1), 3, 1'b0);
    run_line(xy(0, 0, 0), xy(0, 0, 1), 2, 1'b1);
    chk("R7 frame start after blank", {31'd0, last_fs}, 32'd1);
    chk("R8 frame lines", {20'd0, flines}, 32'd3);

    // R10 reprogrammed preamble and swapped active codes
    pre = 24'hFE0101; c_as = 3'd4; c_ae = 3'd0;
    send_trs(xy(0, 0, 1));
    chk("R10 old preamble ignored", {31'd0, line_start}, 32'd0);
    tx_pre = 24'hFE0101;
    run_line(xy(0, 0, 1), xy(0, 0, 0), 4, 1'b1);
    chk("R10 line start new code", {31'd0, last_ls}, 32'd1);

    // R11 reset in mid line
    send_trs(xy(0, 0, 1));
    step(8'h30, 8'h40);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R11 active cleared", {31'd0, vact}, 32'd0);
    chk("R11 counters cleared", {8'd0, ecnt, lpix}, 32'd0);
    chk("R11 frame lines cleared", {20'd0, flines}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step(8'h31, 8'h41);
    step(8'h32, 8'h42);
    chk("R11 hunting after reset", {31'd0, pvld | vact}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule